// File: doc/BRIEF.md
# Frequency-Domain Doppler Bin Rotator

This block removes a carrier frequency offset from a correlation in the frequency domain, not with a time-domain oscillator. An up-link spectrum of N complex bins is first written into an internal bin memory. A second stream then arrives: the local-code spectrum, already conjugated by the producer. For each local bin k, the block multiplies it by the stored up-link bin at index (k − DS·n) mod N. DS is a signed Doppler subrange number and n is a configured minimum bin step. Shifting the spectrum by one bin equals a frequency shift of one resolution step, the sample rate divided by N. So each subrange value selects one slice of the Doppler search space. The product stream is meant to feed an inverse transform.

The subrange values form an odd, symmetric set centred on zero. Neighbouring slices partly overlap, and the slices are searched one after another. A retune strobe therefore replays the held spectrum under a new subrange without reloading it. A start strobe begins a fresh block. The local-code stream is refused until the whole up-link block has been stored.

Top module: `doppler_bin_rotator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `loc_ready_o` and `out_valid_o` are 0.
- R2: After `start_i`, the next N cycles with `up_valid_i` high write up-link bins 0 to N−1 in order. `loc_ready_o` stays 0 until the last of them is written and is 1 in the cycle after that write.
- R3: The local bin accepted as the k-th beat since the block became ready, or since the last retune, gives the complex product loc·up[(k − DS·n) mod N]. The product uses re = lr·ur − li·ui and im = lr·ui + li·ur.
- R4: DS is a two's-complement value of `DSW` bits. Negative values rotate the read index the opposite way. DS·n wraps modulo N, and n is an unsigned `AW`-bit value. Both are captured on `start_i` or on an accepted retune.
- R5: Each product component is rounded by adding 2^(DW−2) and shifting right arithmetically by DW−1. It is then clamped to the range −2^(DW−1) to 2^(DW−1)−1.
- R6: Each accepted local beat (`loc_valid_i` and `loc_ready_o` both high at a clock edge) produces exactly one output with `out_valid_o` high. That output appears two clock edges later, and outputs keep the order of the beats.
- R7: After N local beats have been accepted, `loc_ready_o` returns to 0. Local beats offered while `loc_ready_o` is 0 produce no output.
- R8: `retune_i`, taken when the block is streaming or finished, captures a new DS and n and restarts the local index at 0. It keeps the stored bins and raises `loc_ready_o` in the following cycle.
- R9: `up_valid_i` while the block is not loading leaves the stored bins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new block: capture subrange and step, then load |
| retune_i | input | 1 | Replay the stored block with a new subrange |
| subrange_i | input | DSW | Signed Doppler subrange number |
| bin_step_i | input | AW | Minimum bin shift per subrange |
| up_valid_i | input | 1 | Up-link bin valid |
| up_re_i | input | DW | Up-link bin, real part |
| up_im_i | input | DW | Up-link bin, imaginary part |
| loc_valid_i | input | 1 | Conjugated local-code bin valid |
| loc_re_i | input | DW | Local bin, real part |
| loc_im_i | input | DW | Local bin, imaginary part |
| loc_ready_o | output | 1 | Block stored; local bins accepted |
| out_valid_o | output | 1 | Product valid |
| out_re_o | output | DW | Product, real part |
| out_im_o | output | DW | Product, imaginary part |

## Verification
The bench builds the block with DW = 8, AW = 4 (sixteen bins) and DSW = 5. With so few bins, a product DS·n wraps the read index several times over. The extreme subrange values −16 and +15 can therefore be reached, along with step values whose offsets land on zero and on odd residues. With eight-bit samples, full-scale operands push both components past the clamp limits in both directions, and the rounding boundary is hit often. A sixteen-beat block also lets the bench probe the exact cycle at which the ready flag rises and falls.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SCAN = 2'd2,
    ST_DONE = 2'd3
  } dbr_state_e;

endpackage

// File: rtl/dbr_addr_rot.sv
module dbr_addr_rot #(
  parameter int AW  = 10,
  parameter int DSW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic signed [DSW-1:0] subrange,
  input  logic [AW-1:0]         bin_step,
  input  logic [AW-1:0]         idx,
  output logic [AW-1:0]         rd_addr
);

  // Bin offset DS*n modulo 2^AW: sign-extend or truncate DS to AW bits, then
  // an AW-bit product wraps on its own.
  function automatic logic [AW-1:0] bin_offset(input logic signed [DSW-1:0] ds,
                                               input logic [AW-1:0] step);
    logic [AW-1:0] ds_w;
    ds_w = AW'(ds);
    return ds_w * step;
  endfunction

  logic [AW-1:0] offset_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       offset_q <= '0;
    else if (capture) offset_q <= bin_offset(subrange, bin_step);
  end

  // Wrap-around subtractor: (k - DS*n) mod N
  assign rd_addr = idx - offset_q;

endmodule

// File: rtl/dbr_bin_store.sv
module dbr_bin_store #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_re,
  input  logic [DW-1:0] wr_im,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_re,
  output logic [DW-1:0] rd_im
);

  localparam int NB = 1 << AW;

  logic [2*DW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_re, wr_im};
  end

  always_ff @(posedge clk) begin
    if (rd_en) {rd_re, rd_im} <= mem[rd_addr];
  end

endmodule

// File: rtl/dbr_cmul_rs.sv
module dbr_cmul_rs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] a_re,
  input  logic [DW-1:0] a_im,
  input  logic [DW-1:0] b_re,
  input  logic [DW-1:0] b_im,
  output logic          out_valid,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im
);

  localparam int PW = 2*DW + 1;
  localparam int SH = DW - 1;

  // Round half up at bit DW-1, arithmetic shift, clamp to DW signed bits.
  function automatic logic [DW-1:0] round_sat(input logic signed [PW-1:0] x);
    logic signed [PW:0] t;
    logic signed [PW:0] s;
    t = $signed({x[PW-1], x}) + $signed({{(DW+3){1'b0}}, 1'b1, {(DW-2){1'b0}}});
    s = t >>> SH;
    if (s > $signed({{(DW+3){1'b0}}, {(DW-1){1'b1}}}))
      return {1'b0, {(DW-1){1'b1}}};
    else if (s < $signed({{(DW+3){1'b1}}, {(DW-1){1'b0}}}))
      return {1'b1, {(DW-1){1'b0}}};
    else
      return s[DW-1:0];
  endfunction

  logic signed [PW-1:0] prod_re;
  logic signed [PW-1:0] prod_im;

  always_comb begin
    prod_re = PW'($signed(a_re) * $signed(b_re)) - PW'($signed(a_im) * $signed(b_im));
    prod_im = PW'($signed(a_re) * $signed(b_im)) + PW'($signed(a_im) * $signed(b_re));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= round_sat(prod_re);
        out_im <= round_sat(prod_im);
      end
    end
  end

endmodule

// File: rtl/doppler_bin_rotator.sv
module doppler_bin_rotator
  import dbr_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 10,
  parameter int DSW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  retune_i,
  input  logic signed [DSW-1:0] subrange_i,
  input  logic [AW-1:0]         bin_step_i,
  input  logic                  up_valid_i,
  input  logic [DW-1:0]         up_re_i,
  input  logic [DW-1:0]         up_im_i,
  input  logic                  loc_valid_i,
  input  logic [DW-1:0]         loc_re_i,
  input  logic [DW-1:0]         loc_im_i,
  output logic                  loc_ready_o,
  output logic                  out_valid_o,
  output logic [DW-1:0]         out_re_o,
  output logic [DW-1:0]         out_im_o
);

  localparam int NB = 1 << AW;
  localparam logic [AW-1:0] LAST_BIN = AW'(NB - 1);

  dbr_state_e    state_q;
  logic [AW-1:0] wr_cnt_q;
  logic [AW-1:0] rd_idx_q;
  logic          block_loaded_q;

  // Named internal events
  logic          wr_fire;
  logic          load_last;
  logic          acc_fire;
  logic          scan_last;
  logic          retune_ok;
  logic          retarget;
  logic [AW-1:0] rd_addr;

  assign loc_ready_o = (state_q == ST_SCAN);
  assign wr_fire     = (state_q == ST_LOAD) && up_valid_i && !start_i;
  assign load_last   = wr_fire && (wr_cnt_q == LAST_BIN);
  assign acc_fire    = loc_valid_i && loc_ready_o;
  assign scan_last   = acc_fire && (rd_idx_q == LAST_BIN);
  assign retune_ok   = retune_i && ((state_q == ST_SCAN) || (state_q == ST_DONE));
  assign retarget    = start_i || retune_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      wr_cnt_q       <= '0;
      rd_idx_q       <= '0;
      block_loaded_q <= 1'b0;
    end else if (start_i) begin
      state_q        <= ST_LOAD;
      wr_cnt_q       <= '0;
      rd_idx_q       <= '0;
      block_loaded_q <= 1'b0;
    end else if (retune_ok) begin
      state_q  <= ST_SCAN;
      rd_idx_q <= '0;
    end else begin
      case (state_q)
        ST_LOAD: begin
          if (wr_fire) wr_cnt_q <= wr_cnt_q + 1'b1;
          if (load_last) begin
            state_q        <= ST_SCAN;
            rd_idx_q       <= '0;
            block_loaded_q <= 1'b1;
          end
        end
        ST_SCAN: begin
          if (acc_fire) rd_idx_q <= rd_idx_q + 1'b1;
          if (scan_last) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  dbr_addr_rot #(.AW(AW), .DSW(DSW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (retarget),
    .subrange (subrange_i),
    .bin_step (bin_step_i),
    .idx      (rd_idx_q),
    .rd_addr  (rd_addr)
  );

  logic [DW-1:0] up_rd_re;
  logic [DW-1:0] up_rd_im;

  dbr_bin_store #(.DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_addr (wr_cnt_q),
    .wr_re   (up_re_i),
    .wr_im   (up_im_i),
    .rd_en   (acc_fire),
    .rd_addr (rd_addr),
    .rd_re   (up_rd_re),
    .rd_im   (up_rd_im)
  );

  // Align the local bin with the synchronous memory read
  logic          stg_valid_q;
  logic [DW-1:0] loc_re_q;
  logic [DW-1:0] loc_im_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_valid_q <= 1'b0;
      loc_re_q    <= '0;
      loc_im_q    <= '0;
    end else begin
      stg_valid_q <= acc_fire;
      if (acc_fire) begin
        loc_re_q <= loc_re_i;
        loc_im_q <= loc_im_i;
      end
    end
  end

  dbr_cmul_rs #(.DW(DW)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (stg_valid_q),
    .a_re      (loc_re_q),
    .a_im      (loc_im_q),
    .b_re      (up_rd_re),
    .b_im      (up_rd_im),
    .out_valid (out_valid_o),
    .out_re    (out_re_o),
    .out_im    (out_im_o)
  );

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          loc_ready_o,
  input logic          out_valid_o,
  input logic          acc_fire,
  input logic          scan_last,
  input logic          retarget,
  input logic          block_loaded_q,
  input logic [AW-1:0] rd_addr
);

  assert_ready_needs_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ready_o |-> block_loaded_q);

  assert_two_edge_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(acc_fire, 2));

  assert_read_walks_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && $past(acc_fire) && !$past(retarget)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

  assert_ready_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_ready_o) |-> $past(scan_last || start_i));

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!loc_ready_o && !out_valid_o));

endmodule

bind doppler_bin_rotator dbr_checker #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .loc_ready_o    (loc_ready_o),
  .out_valid_o    (out_valid_o),
  .acc_fire       (acc_fire),
  .scan_last      (scan_last),
  .retarget       (retarget),
  .block_loaded_q (block_loaded_q),
  .rd_addr        (rd_addr)
);

// File: tb/doppler_bin_rotator_tb.sv
module doppler_bin_rotator_tb;

  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int DSW = 5;
  localparam int NB  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic retune_i = 1'b0;
  logic signed [DSW-1:0] subrange_i = '0;
  logic [AW-1:0] bin_step_i = '0;
  logic up_valid_i = 1'b0;
  logic [DW-1:0] up_re_i = '0;
  logic [DW-1:0] up_im_i = '0;
  logic loc_valid_i = 1'b0;
  logic [DW-1:0] loc_re_i = '0;
  logic [DW-1:0] loc_im_i = '0;
  logic loc_ready_o;
  logic out_valid_o;
  logic [DW-1:0] out_re_o;
  logic [DW-1:0] out_im_o;

  always #10 clk = ~clk;

  doppler_bin_rotator #(.DW(DW), .AW(AW), .DSW(DSW)) u_dut (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int up_re_m [NB];
  int up_im_m [NB];
  int cur_ds = 0;
  int cur_step = 0;

  int q_re[$];
  int q_im[$];
  int q_cyc[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  // Requirement-level model of one product component (R5)
  function automatic int scale(input int e);
    int r;
    r = (e + (1 << (DW-2))) >>> (DW-1);
    if (r > (1 << (DW-1)) - 1) r = (1 << (DW-1)) - 1;
    if (r < -(1 << (DW-1))) r = -(1 << (DW-1));
    return r;
  endfunction

  function automatic int wrapn(input int v);
    return ((v % NB) + NB) % NB;
  endfunction

  function automatic int pat(input int k, input int seed);
    return ((k * 37 + seed * 53 + 11) % 256) - 128;
  endfunction

  // Monitor: pops one expected item for every valid output
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (q_re.size() == 0) begin
        check(1'b0, "R7 output with no accepted beat", 1, 0);
      end else begin
        int er, ei, ec;
        string tg;
        er = q_re.pop_front();
        ei = q_im.pop_front();
        ec = q_cyc.pop_front();
        tg = q_tag.pop_front();
        check(sx(out_re_o) == er, {tg, " real"}, sx(out_re_o), er);
        check(sx(out_im_o) == ei, {tg, " imag"}, sx(out_im_o), ei);
        check(cyc == ec, "R6 output cycle", cyc, ec);
      end
    end
  end

  task automatic do_start(input int ds, input int step);
    start_i = 1'b1;
    subrange_i = DSW'(ds);
    bin_step_i = AW'(step);
    cur_ds = ds;
    cur_step = step;
    @(negedge clk);
    start_i = 1'b0;
    check(loc_ready_o == 1'b0, "R2 not ready right after start", loc_ready_o, 0);
  endtask

  task automatic do_retune(input int ds, input int step);
    retune_i = 1'b1;
    subrange_i = DSW'(ds);
    bin_step_i = AW'(step);
    cur_ds = ds;
    cur_step = step;
    @(negedge clk);
    retune_i = 1'b0;
    check(loc_ready_o == 1'b1, "R8 ready after retune", loc_ready_o, 1);
  endtask

  // mode 0: pattern, 1: positive extremes, 2: mixed extremes
  task automatic load_block(input int seed, input int mode);
    for (int k = 0; k < NB; k++) begin
      int vr, vi;
      if (k == 6) begin
        up_valid_i = 1'b0;
        @(negedge clk);
      end
      case (mode)
        1: begin vr = 127; vi = -128; end
        2: begin vr = (k % 2) ? -128 : 127; vi = (k % 3 == 0) ? 127 : -128; end
        default: begin vr = pat(k, seed); vi = pat(k + 5, seed + 3); end
      endcase
      up_valid_i = 1'b1;
      up_re_i = DW'(vr);
      up_im_i = DW'(vi);
      up_re_m[k] = vr;
      up_im_m[k] = vi;
      check(loc_ready_o == 1'b0, "R2 ready low during load", loc_ready_o, 0);
      @(negedge clk);
    end
    up_valid_i = 1'b0;
    check(loc_ready_o == 1'b1, "R2 ready one cycle after last write", loc_ready_o, 1);
  endtask

  task automatic stream(input int seed, input int mode, input string tag);
    int off;
    int k;
    off = wrapn(cur_ds * cur_step);
    k = 0;
    while (k < NB) begin
      if (k % 5 == 2 && loc_valid_i) begin
        loc_valid_i = 1'b0;
        @(negedge clk);
      end
      begin
        int lr, li, ix, ur, ui;
        case (mode)
          1: begin lr = -128; li = 127; end
          2: begin lr = (k % 2) ? 127 : -128; li = (k % 4 < 2) ? -128 : 127; end
          default: begin lr = pat(k + 9, seed); li = pat(k + 2, seed + 7); end
        endcase
        ix = wrapn(k - off);
        ur = up_re_m[ix];
        ui = up_im_m[ix];
        loc_valid_i = 1'b1;
        loc_re_i = DW'(lr);
        loc_im_i = DW'(li);
        if (loc_ready_o) begin
          q_re.push_back(scale(lr * ur - li * ui));
          q_im.push_back(scale(lr * ui + li * ur));
          q_cyc.push_back(cyc + 2);
          q_tag.push_back(tag);
          k++;
        end
        @(negedge clk);
      end
    end
    loc_valid_i = 1'b0;
    check(loc_ready_o == 1'b0, "R7 ready low after N beats", loc_ready_o, 0);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check(q_re.size() == 0, "R6 every beat produced an output", q_re.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(loc_ready_o == 1'b0, "R1 ready in reset", loc_ready_o, 0);
    check(out_valid_o == 1'b0, "R1 valid in reset", out_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(loc_ready_o == 1'b0, "R1 ready after reset", loc_ready_o, 0);
    check(out_valid_o == 1'b0, "R1 valid after reset", out_valid_o, 0);

    // Local beats before any block is loaded: no output (R7)
    loc_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    loc_valid_i = 1'b0;

    // Positive subrange, wrapping offset (R3, R4)
    do_start(1, 3);
    loc_valid_i = 1'b1;   // offered during load: must be refused (R2, R7)
    load_block(1, 0);
    loc_valid_i = 1'b0;
    stream(2, 0, "R3 ds=+1 n=3");
    loc_valid_i = 1'b1;   // extra beats after block end (R7)
    repeat (3) @(negedge clk);
    loc_valid_i = 1'b0;
    drain();

    // Retune to negative subranges on the same stored block (R4, R8)
    do_retune(-3, 5);
    stream(3, 0, "R4 ds=-3 n=5");
    drain();
    do_retune(-16, 5);
    stream(4, 0, "R4 ds=-16 n=5");
    drain();
    do_retune(15, 7);
    stream(5, 0, "R4 ds=+15 n=7");
    drain();

    // Up-link writes outside loading leave the store intact (R9)
    up_valid_i = 1'b1;
    up_re_i = 8'h55;
    up_im_i = 8'hAA;
    repeat (4) @(negedge clk);
    up_valid_i = 1'b0;
    do_retune(2, 1);
    stream(6, 0, "R9 store unchanged");
    drain();

    // Extreme operands drive rounding and clamping (R5)
    do_start(0, 4);
    load_block(0, 1);
    stream(0, 1, "R5 clamp positive/negative");
    drain();
    do_start(-1, 9);
    load_block(0, 2);
    stream(0, 2, "R5 mixed extremes");
    drain();

    // A start in the middle of a scan aborts it (R2)
    do_start(1, 1);
    load_block(8, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(loc_ready_o == 1'b0, "R2 restart drops ready", loc_ready_o, 0);
    load_block(9, 0);
    stream(10, 0, "R3 after restart");
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule